// File: doc/BRIEF.md
# Card Data FIFO Packer

This block sits between a word-wide data FIFO on the host side and a byte-wide card data port. It has one engine that runs in one of two directions. In the receive direction it gathers bytes arriving from the card into 32-bit words and pushes each word into the FIFO, where the host pops it. In the send direction it pops words that the host has pushed and sends their bytes to the card one at a time. Both card-side streams use a plain valid/ready handshake, and at most one byte crosses per clock.

A transfer starts when the control strobe is written with the enable bit set. That write latches the direction and copies the programmed length into the byte counter. The engine then runs until the counter reaches zero. It stays enabled until the FIFO has also emptied, and then it disables itself. Two sticky end flags show that the count is done. Two five-bit flag groups, one for each direction, report the FIFO fill state. Only the group that matches the current direction carries any value.

Top module: `card_fifo_packer`

## Requirements
- R1: After reset the engine is disabled, the byte counter is 0, `rx_ready`, `tx_valid`, `host_pop_err`, `data_end` and `block_end` are 0, and both flag groups are 0.
- R2: A `cfg_wr` pulse with `cfg_en`=1 loads `byte_cnt` from `cfg_len` and clears `data_end` and `block_end` on the next edge. `cfg_dir`=1 selects receive (card to FIFO) and `cfg_dir`=0 selects send (FIFO to card).
- R3: In receive, `rx_ready` is high only while the engine is enabled, `byte_cnt` is nonzero and the FIFO holds fewer than 16 words. Each accepted byte decrements `byte_cnt`. Bytes pack little-endian: byte 4k+j of the transfer lands in bits 8j+7:8j of word k. While the FIFO has room, one byte is taken every cycle.
- R4: In receive, when the count reaches zero in the middle of a word, that partial word is pushed with its unfilled upper bytes zero.
- R5: In send, a word is popped only when no bytes of the previous word remain. Its bytes go out lowest first on `tx_data`. Each accepted byte decrements `byte_cnt`. A byte is held while `tx_ready` is low, and `tx_valid` is 0 once `byte_cnt` is 0.
- R6: Once the byte counter is zero while the engine is enabled, `data_end` and `block_end` both become 1. They stay 1 until the next enabling `cfg_wr`, and a zero length sets them at once.
- R7: The engine disables itself one edge after it sees `byte_cnt`=0 with an empty FIFO. It stays enabled while the FIFO still holds words.
- R8: The flag groups use these bit positions: [0] active, [1] empty (level 0), [2] available (level not 0), [3] half (`rx_flags`: level at least 8; `tx_flags`: level at most 8), [4] full (level 16). Only the group that matches the enabled direction is nonzero, and both groups are 0 while the engine is disabled.
- R9: The FIFO is a 16-word circular buffer and returns words in push order across pointer wrap. A host push to a full FIFO is dropped.
- R10: A host pop from an empty FIFO returns 0 on `host_rdata`, and `host_pop_err` pulses for one cycle on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable bit of the control write |
| cfg_dir | input | 1 | Direction of the control write, 1 = receive |
| cfg_len | input | 16 | Programmed transfer length in bytes |
| host_push | input | 1 | Host pushes `host_wdata` into the FIFO |
| host_wdata | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host pops the FIFO head |
| host_rdata | output | 32 | FIFO head, 0 when empty |
| host_pop_err | output | 1 | One-cycle pulse after a pop from an empty FIFO |
| rx_valid | input | 1 | Card byte offered |
| rx_data | input | 8 | Card byte |
| rx_ready | output | 1 | Engine takes a card byte |
| tx_valid | output | 1 | Byte offered to the card |
| tx_data | output | 8 | Byte to the card |
| tx_ready | input | 1 | Card takes the byte |
| eng_en | output | 1 | Engine enabled |
| byte_cnt | output | 16 | Bytes left in the transfer |
| data_end | output | 1 | Sticky data-end flag |
| block_end | output | 1 | Sticky block-end flag |
| rx_flags | output | 5 | Receive FIFO flags |
| tx_flags | output | 5 | Transmit FIFO flags |

## Verification
Receive and send are each swept over every length from 0 to 20 bytes. This covers every trailing-byte remainder, so a lane or zero-fill error shows up as a wrong word at a known length. A 70-byte receive fills all 16 words, which separates the full-FIFO stall from the free-running one-byte-per-cycle case. Send is also run with a card that stalls every third cycle, which shows whether a byte is held or skipped. Separate level sweeps fill the FIFO from 0 to 16 in the receive direction and drain it from 16 to 0 in the send direction. These sweeps compare every flag threshold and the push order against arithmetic expectations, and then try an overflowing push and an underflowing pop.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    typedef enum logic {
        DIR_SEND = 1'b0,
        DIR_RECV = 1'b1
    } dir_e;

    localparam int FLAG_W     = 5;
    localparam int FLG_ACTIVE = 0;
    localparam int FLG_EMPTY  = 1;
    localparam int FLG_AVAIL  = 2;
    localparam int FLG_HALF   = 3;
    localparam int FLG_FULL   = 4;
endpackage

// File: rtl/cfp_ring.sv
// Circular word buffer: read pointer plus fill level. DEPTH must be a power of two.
module cfp_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } ring_s;

    ring_s            r_q, r_d;
    logic [W-1:0]     mem [DEPTH];
    logic             do_push, do_pop;
    logic [PTR_W-1:0] wr_idx;

    assign full  = (r_q.lvl == LVL_W'(DEPTH));
    assign empty = (r_q.lvl == '0);
    assign level = r_q.lvl;
    assign head  = mem[r_q.rd];

    always_comb begin
        r_d     = r_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        wr_idx  = PTR_W'(r_q.rd + PTR_W'(r_q.lvl));
        if (do_pop) begin
            r_d.rd = r_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   r_d.lvl = r_q.lvl + 1'b1;
            2'b01:   r_d.lvl = r_q.lvl - 1'b1;
            default: r_d.lvl = r_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_idx] <= push_data;
    end

    // R9: a push into a full buffer leaves the level unchanged
    a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == $past(level)));
    // R9: the level never exceeds the depth
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
endmodule

// File: rtl/cfp_flags.sv
// Direction-qualified FIFO flags computed from the fill level.
module cfp_flags
    import cfp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int HALF  = DEPTH / 2
) (
    input  logic             en,
    input  dir_e             dir,
    input  logic [LVL_W-1:0] level,
    output logic [FLAG_W-1:0] rx_flags,
    output logic [FLAG_W-1:0] tx_flags
);
    logic [FLAG_W-1:0] rx_raw, tx_raw;

    always_comb begin
        rx_raw = '0;
        tx_raw = '0;
        rx_raw[FLG_ACTIVE] = 1'b1;
        tx_raw[FLG_ACTIVE] = 1'b1;
        rx_raw[FLG_EMPTY]  = (level == '0);
        tx_raw[FLG_EMPTY]  = (level == '0);
        rx_raw[FLG_AVAIL]  = (level != '0);
        tx_raw[FLG_AVAIL]  = (level != '0);
        rx_raw[FLG_HALF]   = (level >= LVL_W'(HALF));
        tx_raw[FLG_HALF]   = (level <= LVL_W'(HALF));
        rx_raw[FLG_FULL]   = (level == LVL_W'(DEPTH));
        tx_raw[FLG_FULL]   = (level == LVL_W'(DEPTH));
        rx_flags = (en && dir == DIR_RECV) ? rx_raw : '0;
        tx_flags = (en && dir == DIR_SEND) ? tx_raw : '0;
    end
endmodule

// File: rtl/cfp_engine.sv
// Byte-counting engine: packs card bytes into words or unpacks words into bytes.
module cfp_engine
    import cfp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int BYTES  = WORD_W / 8,
    localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int REM_W  = $clog2(BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic              cfg_dir,
    input  logic [CNT_W-1:0]  cfg_len,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_head,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              pop,
    output logic              en,
    output dir_e              dir,
    output logic [CNT_W-1:0]  cnt,
    output logic              data_end,
    output logic              block_end
);
    typedef struct packed {
        logic              en;
        dir_e              dir;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] acc;
        logic [LANE_W-1:0] lane;
        logic [WORD_W-1:0] hold;
        logic [REM_W-1:0]  rem;
        logic              dend;
        logic              bend;
    } eng_s;

    eng_s              s_q, s_d;
    logic              rx_fire, tx_fire, last_byte, cnt_nz;
    logic [WORD_W-1:0] word_ins;

    assign cnt_nz    = (s_q.cnt != '0);
    assign rx_ready  = s_q.en && (s_q.dir == DIR_RECV) && cnt_nz && !fifo_full;
    assign tx_valid  = s_q.en && (s_q.dir == DIR_SEND) && cnt_nz && (s_q.rem != '0);
    assign tx_data   = s_q.hold[7:0];
    assign rx_fire   = rx_valid && rx_ready;
    assign tx_fire   = tx_valid && tx_ready;
    assign word_ins  = s_q.acc | (WORD_W'(rx_data) << {s_q.lane, 3'b000});
    assign last_byte = (s_q.lane == LANE_W'(BYTES - 1)) || (s_q.cnt == CNT_W'(1));
    assign push      = rx_fire && last_byte;
    assign push_word = word_ins;
    assign pop       = s_q.en && (s_q.dir == DIR_SEND) && cnt_nz
                       && (s_q.rem == '0) && !fifo_empty;

    assign en        = s_q.en;
    assign dir       = s_q.dir;
    assign cnt       = s_q.cnt;
    assign data_end  = s_q.dend;
    assign block_end = s_q.bend;

    always_comb begin
        s_d = s_q;
        if (rx_fire) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (last_byte) begin
                s_d.acc  = '0;
                s_d.lane = '0;
            end else begin
                s_d.acc  = word_ins;
                s_d.lane = s_q.lane + 1'b1;
            end
        end
        if (tx_fire) begin
            s_d.cnt  = s_q.cnt - 1'b1;
            s_d.hold = s_q.hold >> 8;
            s_d.rem  = s_q.rem - 1'b1;
        end
        if (pop) begin
            s_d.hold = fifo_head;
            s_d.rem  = REM_W'(BYTES);
        end
        if (s_q.en && !cnt_nz) begin
            s_d.dend = 1'b1;
            s_d.bend = 1'b1;
            if (fifo_empty) s_d.en = 1'b0;
        end
        if (cfg_wr) begin
            s_d.en  = cfg_en;
            s_d.dir = dir_e'(cfg_dir);
            if (cfg_en) begin
                s_d.cnt  = cfg_len;
                s_d.acc  = '0;
                s_d.lane = '0;
                s_d.hold = '0;
                s_d.rem  = '0;
                s_d.dend = 1'b0;
                s_d.bend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: every accepted card byte takes one off the counter
    a_r3_rx_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !cfg_wr) |=> (cnt == $past(cnt) - 1'b1));
    // R3: never push into a full FIFO
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full);
    // R5: every accepted outgoing byte takes one off the counter
    a_r5_tx_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !cfg_wr) |=> (cnt == $past(cnt) - 1'b1));
    // R5: a stalled byte stays on the port
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !cfg_wr) |=> (tx_valid && $stable(tx_data)));
    // R6: end flags are sticky until a new enable
    a_r6_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (data_end && !cfg_wr) |=> data_end);
    // R7: idle once the count is done and the FIFO is drained
    a_r7_auto_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == '0 && fifo_empty && !cfg_wr) |=> !en);
endmodule

// File: rtl/card_fifo_packer.sv
module card_fifo_packer
    import cfp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic              cfg_dir,
    input  logic [CNT_W-1:0]  cfg_len,
    input  logic              host_push,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_pop_err,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              eng_en,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              data_end,
    output logic              block_end,
    output logic [FLAG_W-1:0] rx_flags,
    output logic [FLAG_W-1:0] tx_flags
);
    logic              eng_push, eng_pop, ring_push, ring_pop;
    logic              fifo_full, fifo_empty;
    logic [WORD_W-1:0] eng_word, ring_wdata, fifo_head;
    logic [LVL_W-1:0]  fifo_level;
    dir_e              eng_dir;
    logic              err_q, err_d;

    // Engine push takes the write port; host pops and engine pops share the read port.
    assign ring_push  = eng_push || host_push;
    assign ring_wdata = eng_push ? eng_word : host_wdata;
    assign ring_pop   = eng_pop || host_pop;
    assign host_rdata = fifo_empty ? '0 : fifo_head;
    assign err_d      = host_pop && fifo_empty;
    assign host_pop_err = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    cfp_ring #(.DEPTH(DEPTH), .W(WORD_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ring_push),
        .push_data (ring_wdata),
        .pop       (ring_pop),
        .head      (fifo_head),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    cfp_engine #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_en     (cfg_en),
        .cfg_dir    (cfg_dir),
        .cfg_len    (cfg_len),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .push       (eng_push),
        .push_word  (eng_word),
        .pop        (eng_pop),
        .en         (eng_en),
        .dir        (eng_dir),
        .cnt        (byte_cnt),
        .data_end   (data_end),
        .block_end  (block_end)
    );

    cfp_flags #(.DEPTH(DEPTH)) u_flags (
        .en       (eng_en),
        .dir      (eng_dir),
        .level    (fifo_level),
        .rx_flags (rx_flags),
        .tx_flags (tx_flags)
    );

    // R10: popping an empty FIFO is reported on the next cycle
    a_r10_pop_err: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && host_rdata == '0 && rx_flags[FLG_EMPTY]) |=> host_pop_err);
    // R8: a disabled engine reports no flags
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_en |-> (rx_flags == '0 && tx_flags == '0));
    // R8: the two groups are never both active
    a_r8_one_group: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_flags[FLG_ACTIVE], tx_flags[FLG_ACTIVE]}));
endmodule

// File: tb/sim_card_fifo_packer.sv
module sim_card_fifo_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, cfg_en = 0, cfg_dir = 0;
    logic [15:0] cfg_len = '0;
    logic        host_push = 0, host_pop = 0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_pop_err;
    logic        rx_valid = 0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_ready = 0;
    logic [7:0]  tx_data;
    logic        eng_en, data_end, block_end;
    logic [15:0] byte_cnt;
    logic [4:0]  rx_flags, tx_flags;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    card_fifo_packer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
        .cfg_len(cfg_len), .host_push(host_push), .host_wdata(host_wdata),
        .host_pop(host_pop), .host_rdata(host_rdata), .host_pop_err(host_pop_err),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .eng_en(eng_en), .byte_cnt(byte_cnt), .data_end(data_end),
        .block_end(block_end), .rx_flags(rx_flags), .tx_flags(tx_flags)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] bval(input int len, input int i);
        return 8'((i * 37 + len * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] rword(input int len, input int k);
        logic [31:0] w = '0;
        for (int b = 0; b < 4; b++)
            if (4 * k + b < len) w |= 32'(bval(len, 4 * k + b)) << (8 * b);
        return w;
    endfunction

    function automatic logic [31:0] sword(input int len, input int k);
        return (32'(k) * 32'h01010101) ^ (32'(len) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [4:0] expf(input int lvl, input bit rx);
        logic half = rx ? (lvl >= 8) : (lvl <= 8);
        return {lvl == 16, half, lvl != 0, lvl == 0, 1'b1};
    endfunction

    task automatic cfg_write(input bit en, input bit dir, input int len);
        cfg_wr = 1; cfg_en = en; cfg_dir = dir; cfg_len = 16'(len);
        step();
        cfg_wr = 0;
    endtask

    task automatic feed(input int len, input int from, input int upto, input bit free_run);
        int fed = from;
        int guard = 0;
        logic r;
        while (fed < upto && guard < 5000) begin
            rx_valid = 1;
            rx_data  = bval(len, fed);
            r = rx_ready;
            step();
            guard++;
            if (r) fed++;
        end
        rx_valid = 0;
        chk(fed == upto, "R3", "bytes accepted", fed, upto);
        if (free_run) chk(guard == upto - from, "R3", "cycles per byte", guard, upto - from);
    endtask

    task automatic drain(input int len, input int from, input int n);
        for (int k = from; k < from + n; k++) begin
            chk(host_rdata == rword(len, k), (4 * k + 4 > len) ? "R4" : "R3",
                "packed word", host_rdata, rword(len, k));
            host_pop = 1;
            step();
            host_pop = 0;
        end
    endtask

    task automatic recv(input int len);
        cfg_write(1, 1, len);
        chk(byte_cnt == 16'(len), "R2", "count load", byte_cnt, len);
        chk(data_end == 0 && block_end == 0, "R2", "end flags cleared", data_end, 0);
        feed(len, 0, len, 1);
        chk(byte_cnt == 0, "R3", "count after bytes", byte_cnt, 0);
        if (len > 0) chk(eng_en == 1, "R7", "held while FIFO has data", eng_en, 1);
        drain(len, 0, (len + 3) / 4);
        step(); step();
        chk(eng_en == 0, "R7", "auto idle", eng_en, 0);
        chk(data_end == 1, "R6", "data_end", data_end, 1);
        chk(block_end == 1, "R6", "block_end", block_end, 1);
        chk(rx_flags == 0 && tx_flags == 0, "R8", "idle flags", rx_flags, 0);
    endtask

    task automatic send(input int len, input bit bp);
        int got = 0;
        int guard = 0;
        logic v;
        logic [7:0] d;
        logic [7:0] e;
        for (int k = 0; k < (len + 3) / 4; k++) begin
            host_push = 1; host_wdata = sword(len, k);
            step();
        end
        host_push = 0;
        cfg_write(1, 0, len);
        chk(byte_cnt == 16'(len), "R2", "count load", byte_cnt, len);
        while (got < len && guard < 2000) begin
            tx_ready = bp ? (guard % 3 != 0) : 1'b1;
            v = tx_valid;
            d = tx_data;
            chk(byte_cnt == 16'(len - got), "R5", "count per byte", byte_cnt, len - got);
            step();
            guard++;
            if (v && tx_ready) begin
                e = 8'(sword(len, got / 4) >> (8 * (got % 4)));
                chk(d == e, "R5", "sent byte", d, e);
                got++;
            end
        end
        tx_ready = 1;
        chk(got == len, "R5", "bytes sent", got, len);
        step(); step(); step();
        chk(tx_valid == 0, "R5", "no byte after count", tx_valid, 0);
        chk(eng_en == 0, "R7", "auto idle", eng_en, 0);
        chk(data_end == 1 && block_end == 1, "R6", "end flags", {data_end, block_end}, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        // R1 reset state
        chk(eng_en == 0, "R1", "eng_en", eng_en, 0);
        chk(byte_cnt == 0, "R1", "byte_cnt", byte_cnt, 0);
        chk(rx_ready == 0 && tx_valid == 0, "R1", "port handshakes", {rx_ready, tx_valid}, 0);
        chk(data_end == 0 && block_end == 0 && host_pop_err == 0, "R1", "status bits",
            {data_end, block_end, host_pop_err}, 0);
        chk(rx_flags == 0 && tx_flags == 0, "R1", "flags", {rx_flags, tx_flags}, 0);

        for (int len = 0; len <= 20; len++) recv(len);

        // Full-FIFO stall in receive (R3)
        cfg_write(1, 1, 70);
        feed(70, 0, 64, 1);
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1; rx_data = 8'hEE;
            chk(rx_ready == 0, "R3", "stall when full", rx_ready, 0);
            chk(byte_cnt == 6, "R3", "count frozen", byte_cnt, 6);
            chk(rx_flags == expf(16, 1), "R8", "full rx flags", rx_flags, expf(16, 1));
            step();
        end
        rx_valid = 0;
        drain(70, 0, 16);
        feed(70, 64, 70, 1);
        drain(70, 16, 2);
        step(); step();
        chk(eng_en == 0, "R7", "auto idle after stall", eng_en, 0);

        for (int len = 0; len <= 20; len++) send(len, 0);
        send(13, 1);
        send(22, 1);

        // Send-direction level sweep 16 down to 1 (R8, R9)
        for (int k = 0; k < 16; k++) begin
            host_push = 1; host_wdata = sword(99, k);
            step();
        end
        host_push = 0;
        cfg_write(1, 0, 0);
        for (int k = 0; k < 16; k++) begin
            chk(tx_flags == expf(16 - k, 0), "R8", "tx flags", tx_flags, expf(16 - k, 0));
            chk(rx_flags == 0, "R8", "rx group silent", rx_flags, 0);
            chk(host_rdata == sword(99, k), "R9", "pop order", host_rdata, sword(99, k));
            host_pop = 1;
            step();
            host_pop = 0;
        end
        chk(data_end == 1, "R6", "zero length end", data_end, 1);
        step(); step();
        chk(eng_en == 0 && tx_flags == 0, "R7", "idle after drain", {eng_en, tx_flags}, 0);

        // Receive-direction level sweep 0 up to 16, overflow and underflow
        cfg_write(1, 1, 100);
        for (int k = 0; k <= 16; k++) begin
            chk(rx_flags == expf(k, 1), "R8", "rx flags", rx_flags, expf(k, 1));
            chk(tx_flags == 0, "R8", "tx group silent", tx_flags, 0);
            host_push = 1; host_wdata = sword(77, k);
            step();
        end
        host_push = 0;
        chk(rx_flags == expf(16, 1), "R9", "push on full dropped", rx_flags, expf(16, 1));
        for (int k = 0; k < 16; k++) begin
            chk(host_rdata == sword(77, k), "R9", "wrap order", host_rdata, sword(77, k));
            host_pop = 1;
            step();
            host_pop = 0;
        end
        chk(rx_flags == expf(0, 1), "R9", "extra word absent", rx_flags, expf(0, 1));
        chk(host_rdata == 0, "R10", "empty pop data", host_rdata, 0);
        chk(host_pop_err == 0, "R10", "no error before pop", host_pop_err, 0);
        host_pop = 1;
        step();
        host_pop = 0;
        chk(host_pop_err == 1, "R10", "error pulse", host_pop_err, 1);
        step();
        chk(host_pop_err == 0, "R10", "pulse length", host_pop_err, 0);
        chk(byte_cnt == 100, "R10", "count untouched", byte_cnt, 100);
        cfg_write(0, 1, 0);
        chk(eng_en == 0 && rx_flags == 0, "R8", "disabled flags", {eng_en, rx_flags}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule